// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter for a system controller. Software picks one of seven time-out lengths through a small control register. From then on it must service the watchdog by writing a two-byte sequence to a service register before the count runs out. If the count expires, the block raises a system reset request. It also raises one when the service sequence is malformed or, in window mode, when a service write comes too early. The counter advances once per cycle of the block clock, which is taken to be the watchdog clock.

The mode fields (rate and window enable) can be set only once after each reset in normal operation. In special mode they stay writable. A mask bit in the control write lets a debugger change only the debug-stop bit. With debug-stop set, the count freezes while debug is active. In special mode with debug-stop clear, an active debug session forces the longest period with window mode off. The reset request is a single-cycle pulse that also returns the block to its reset state. The `EXP_SHIFT` parameter lowers every period exponent by the same amount, so that runs are short in simulation.

Top module: `wdog_top`

## Requirements
- R1: Control write layout: bits [2:0] rate, bit 3 window enable, bit 4 debug-stop, bit 5 field mask (write-only). `ctrlQ` reads back {debug-stop, window, rate} as 5 bits. After reset `ctrlQ` is 0 and `rstReq` is low.
- R2: The rate codes 1 to 7 select periods of 2^(e-EXP_SHIFT) cycles, with e = 14, 16, 18, 20, 22, 23, 24 in that order. Rate 0 disables the counter.
- R3: A control write that stores a nonzero rate restarts the count. With no service, `rstReq` is high in the cycle after the P-th counting clock edge that follows the write edge, where P is the period.
- R4: Writing 0x55 and then 0xAA to the service register restarts the count on the 0xAA edge. The next time-out then follows P counting edges later.
- R5: While the watchdog is enabled, a service write of any value other than 0x55 or 0xAA, or a 0xAA with no 0x55 since the last restart, makes `rstReq` high in the cycle right after that write edge.
- R6: With window mode on, a service write seen while the count is below 3P/4 raises `rstReq` on the next cycle. At or above 3P/4, 0x55 may be repeated freely. After the 0xAA restart, an immediate service write raises `rstReq`.
- R7: With debug-stop at 1, the count holds on every edge at which `dbgActive` is high. With debug-stop at 0, the count keeps advancing.
- R8: A control write with the mask bit set updates only debug-stop. It does not consume the once-only allowance for the mode fields.
- R9: In normal mode the rate and window fields accept one unmasked write after reset, and later writes to them are ignored and do not restart the count. In special mode they can be rewritten at any time.
- R10: When enabled, in special mode, with `dbgActive` high and debug-stop 0, the block uses period 2^(24-EXP_SHIFT) and window mode is off. `ctrlQ` still shows the stored fields.
- R11: `rstReq` lasts exactly one cycle. The cycle after it, the control fields, the lock and the count are back at their reset values.
- R12: Service writes while the rate is 0 have no effect and cause no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlData | input | 6 | Control write data (layout in R1) |
| svcWe | input | 1 | Service register write strobe |
| svcData | input | 8 | Service write data |
| dbgActive | input | 1 | Debug session active |
| specialMode | input | 1 | Chip in special operating mode |
| ctrlQ | output | 5 | Control register readback |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
A write is taken at the clock edge where its strobe is high. `ctrlQ` shows a new value at the next falling edge. An error caused by a service write appears on `rstReq` at that same falling edge. A time-out appears after the P-th counting edge measured from the restarting write edge, and frozen debug edges push it out by the same number of edges. The bench drives inputs on falling edges and advances one edge per task step. After each stimulus it records the first edge index at which `rstReq` goes high and compares it with P minus the edges already counted. It then checks one edge later that the pulse has ended and `ctrlQ` reads zero. The rate sweep runs with `EXP_SHIFT` = 10, so every period from 16 to 16384 cycles is measured in full.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic clear;
    logic restart;
    logic run;
  } cntCmd_t;

  typedef struct packed {
    logic expired;
    logic winOpen;
  } cntStat_t;

  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;
  localparam int         TOP_EXP  = 24;

  function automatic logic [4:0] rateExp(input logic [2:0] rate);
    logic [4:0] e;
    case (rate)
      3'd1:    e = 5'd14;
      3'd2:    e = 5'd16;
      3'd3:    e = 5'd18;
      3'd4:    e = 5'd20;
      3'd5:    e = 5'd22;
      3'd6:    e = 5'd23;
      default: e = 5'd24;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int EXP_SHIFT = 0,
  localparam int MAX_EXP = TOP_EXP - EXP_SHIFT,
  localparam int CNT_W = MAX_EXP + 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  cntCmd_t  cmd,
  input  logic [4:0] expSel,
  output cntStat_t stat
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] winStart;

  assign limit    = {{(CNT_W-1){1'b0}}, 1'b1} << expSel;
  assign winStart = limit - (limit >> 2);

  assign stat.expired = (count >= limit - {{(CNT_W-1){1'b0}}, 1'b1});
  assign stat.winOpen = (count >= winStart);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear || cmd.restart) begin
      count <= '0;
    end else if (cmd.run) begin
      count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  // R7: without run, restart or clear the count must not move
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.restart && !cmd.clear) |=> (count == $past(count)));

  // R3: a running count advances by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.restart && !cmd.clear) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int EXP_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [5:0] ctrlData,
  input  logic       svcWe,
  input  logic [7:0] svcData,
  input  logic       dbgActive,
  input  logic       specialMode,
  input  cntStat_t   stat,
  output cntCmd_t    cmd,
  output logic [4:0] expSel,
  output logic [4:0] ctrlQ,
  output logic       rstReq
);

  logic [2:0] rateQ;
  logic       winQ;
  logic       dbgStopQ;
  logic       lockQ;
  logic       armQ;

  logic       enabled;
  logic       forced;
  logic       effWin;
  logic [2:0] effRate;
  logic       hold;
  logic       fieldWr;
  logic       svcLive;
  logic       svcBad;
  logic       svcGood;
  logic       timeout;

  assign enabled = (rateQ != 3'd0);
  assign forced  = enabled && dbgActive && !dbgStopQ && specialMode;
  assign effWin  = winQ && !forced;
  assign effRate = forced ? 3'd7 : rateQ;
  assign expSel  = rateExp(effRate) - 5'(EXP_SHIFT);
  assign hold    = dbgActive && dbgStopQ;

  assign fieldWr = ctrlWe && !ctrlData[5] && (!lockQ || specialMode) && !rstReq;
  assign svcLive = svcWe && enabled && !rstReq;
  assign svcBad  = svcLive && (((svcData != SVC_ARM) && (svcData != SVC_FIRE)) ||
                               ((svcData == SVC_FIRE) && !armQ) ||
                               (effWin && !stat.winOpen));
  assign svcGood = svcLive && !svcBad && (svcData == SVC_FIRE);

  assign cmd.clear   = rstReq;
  assign cmd.run     = enabled && !hold && !rstReq;
  assign cmd.restart = (fieldWr && (ctrlData[2:0] != 3'd0)) || svcGood;
  assign timeout     = cmd.run && stat.expired;

  assign ctrlQ = {dbgStopQ, winQ, rateQ};

  always_ff @(posedge clk) begin
    if (!rstN || rstReq) begin
      rateQ    <= 3'd0;
      winQ     <= 1'b0;
      dbgStopQ <= 1'b0;
      lockQ    <= 1'b0;
      armQ     <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      if (ctrlWe) begin
        dbgStopQ <= ctrlData[4];
      end
      if (fieldWr) begin
        rateQ <= ctrlData[2:0];
        winQ  <= ctrlData[3];
        lockQ <= 1'b1;
      end
      if (cmd.restart) begin
        armQ <= 1'b0;
      end else if (svcLive && !svcBad && (svcData == SVC_ARM)) begin
        armQ <= 1'b1;
      end
      rstReq <= timeout || svcBad;
    end
  end

  // R11: the request is a single-cycle pulse that leaves the fields cleared
  p_pulse_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (!rstReq && (ctrlQ == 5'd0)));

  // R6: a service write before the window opens must lead to a request
  p_early_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (svcLive && effWin && !stat.winOpen) |=> rstReq);

  // R5: 0xAA without a preceding 0x55 must lead to a request
  p_bad_seq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (svcLive && (svcData == SVC_FIRE) && !armQ) |=> rstReq);

  // R12: a disabled watchdog never requests a reset
  p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !rstReq) |=> !rstReq);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int EXP_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [5:0] ctrlData,
  input  logic       svcWe,
  input  logic [7:0] svcData,
  input  logic       dbgActive,
  input  logic       specialMode,
  output logic [4:0] ctrlQ,
  output logic       rstReq
);

  cntCmd_t    cmd;
  cntStat_t   stat;
  logic [4:0] expSel;

  wdog_ctrl #(.EXP_SHIFT(EXP_SHIFT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWe     (ctrlWe),
    .ctrlData   (ctrlData),
    .svcWe      (svcWe),
    .svcData    (svcData),
    .dbgActive  (dbgActive),
    .specialMode(specialMode),
    .stat       (stat),
    .cmd        (cmd),
    .expSel     (expSel),
    .ctrlQ      (ctrlQ),
    .rstReq     (rstReq)
  );

  wdog_count #(.EXP_SHIFT(EXP_SHIFT)) u_count (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .expSel(expSel),
    .stat  (stat)
  );

endmodule

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;

  localparam int SHIFT = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [5:0] ctrlData = '0;
  logic       svcWe = 1'b0;
  logic [7:0] svcData = '0;
  logic       dbgActive = 1'b0;
  logic       specialMode = 1'b0;
  logic [4:0] ctrlQ;
  logic       rstReq;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_top #(.EXP_SHIFT(SHIFT)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .svcWe(svcWe), .svcData(svcData), .dbgActive(dbgActive),
    .specialMode(specialMode), .ctrlQ(ctrlQ), .rstReq(rstReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 200000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic int perOf(input int r);
    int e;
    e = (r <= 5) ? 12 + 2 * r : ((r == 6) ? 23 : 24);
    return 1 << (e - SHIFT);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wrCtrl(input logic [5:0] d);
    ctrlWe = 1'b1;
    ctrlData = d;
    @(posedge clk);
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrSvc(input logic [7:0] d);
    svcWe = 1'b1;
    svcData = d;
    @(posedge clk);
    @(negedge clk);
    svcWe = 1'b0;
  endtask

  // first edge at which rstReq is seen must be n; one edge later it is gone and fields cleared
  task automatic expectPulse(input int n, input string req);
    int first;
    first = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rstReq && first == 0) first = k;
    end
    check(first == n, req, first, n);
    tick(1);
    check(!rstReq && ctrlQ == 5'd0, "R11", {rstReq, ctrlQ}, 0);
  endtask

  initial begin
    int seen;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state
    check(ctrlQ == 5'd0 && !rstReq, "R1", {rstReq, ctrlQ}, 0);

    // R2 R3: full sweep of the rate codes
    for (int r = 1; r <= 7; r++) begin
      wrCtrl(6'(r));
      check(ctrlQ == 5'(r), "R1", ctrlQ, r);
      expectPulse(perOf(r), "R2");
    end

    // R12: disabled block ignores service writes
    wrSvc(8'h12);
    seen = rstReq;
    tick(300);
    seen = seen | rstReq;
    check(seen == 0 && ctrlQ == 5'd0, "R12", seen, 0);

    // R4: correct service restarts the period
    wrCtrl(6'h01);
    tick(9);
    wrSvc(8'h55);
    wrSvc(8'hAA);
    check(!rstReq, "R4", rstReq, 0);
    expectPulse(perOf(1), "R4");

    // R5: illegal value and lone 0xAA
    wrCtrl(6'h01);
    wrSvc(8'h3C);
    check(rstReq, "R5", rstReq, 1);
    tick(1);
    check(!rstReq && ctrlQ == 5'd0, "R11", {rstReq, ctrlQ}, 0);
    wrCtrl(6'h01);
    wrSvc(8'hAA);
    check(rstReq, "R5", rstReq, 1);
    tick(1);

    // R6: window boundary, repeated arm, early write after restart
    wrCtrl(6'h0A);
    check(ctrlQ == 5'h0A, "R1", ctrlQ, 'h0A);
    tick(47);
    wrSvc(8'h55);
    check(rstReq, "R6", rstReq, 1);
    tick(1);
    wrCtrl(6'h0A);
    tick(48);
    wrSvc(8'h55);
    check(!rstReq, "R6", rstReq, 0);
    wrSvc(8'h55);
    check(!rstReq, "R6", rstReq, 0);
    wrSvc(8'hAA);
    check(!rstReq, "R6", rstReq, 0);
    wrSvc(8'h55);
    check(rstReq, "R6", rstReq, 1);
    tick(1);
    wrCtrl(6'h0A);
    tick(60);
    wrSvc(8'h55);
    wrSvc(8'hAA);
    expectPulse(perOf(2), "R6");

    // R7: debug stop holds the count, clear debug stop keeps it running
    wrCtrl(6'h11);
    check(ctrlQ == 5'h11, "R7", ctrlQ, 'h11);
    tick(5);
    dbgActive = 1'b1;
    tick(7);
    dbgActive = 1'b0;
    expectPulse(perOf(1) - 5, "R7");
    wrCtrl(6'h01);
    tick(5);
    dbgActive = 1'b1;
    tick(7);
    dbgActive = 1'b0;
    expectPulse(perOf(1) - 12, "R7");

    // R9: second write ignored in normal mode; R8: masked write touches only debug-stop
    wrCtrl(6'h01);
    wrCtrl(6'h0B);
    check(ctrlQ == 5'h01, "R9", ctrlQ, 1);
    wrCtrl(6'h3F);
    check(ctrlQ == 5'h11, "R8", ctrlQ, 'h11);
    expectPulse(perOf(1) - 2, "R9");
    wrCtrl(6'h3A);
    check(ctrlQ == 5'h10, "R8", ctrlQ, 'h10);
    wrCtrl(6'h03);
    check(ctrlQ == 5'h03, "R8", ctrlQ, 3);
    expectPulse(perOf(3), "R8");

    // R9: special mode keeps the fields writable and the rewrite restarts
    specialMode = 1'b1;
    wrCtrl(6'h01);
    tick(3);
    wrCtrl(6'h02);
    check(ctrlQ == 5'h02, "R9", ctrlQ, 2);
    expectPulse(perOf(2), "R9");

    // R10: forced longest period, window off, fields kept
    wrCtrl(6'h09);
    dbgActive = 1'b1;
    wrSvc(8'h55);
    check(!rstReq, "R10", rstReq, 0);
    wrSvc(8'hAA);
    check(!rstReq && ctrlQ == 5'h09, "R10", {rstReq, ctrlQ}, 'h09);
    expectPulse(1 << (24 - SHIFT), "R10");
    dbgActive = 1'b0;
    specialMode = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule